// File: doc/BRIEF.md
# Dual-Channel PWM Register Block

This block is a memory-mapped controller for two pulse-width channels. Each channel has a phase-accumulator oscillator (the variable-frequency source) whose most significant bit forms a square wave. The rising edges of that wave step a period/on-time counter (the constant-frequency source). A per-channel select bit chooses which of the two signals reaches the channel's pin. Per-channel control bits start the channel, force its pin high, enable the pad driver (active-low) and put the pad into open-drain mode.

Software programs the block through a single-cycle 32-bit register port with byte offsets. Reads are combinational from the address. To enable a channel, software clears its output-enable-bar bit and sets its start and open-drain bits. To disable it, software does the reverse.

Top module: `pwm2_ctrl`

## Requirements
- R1: After a synchronous reset, the control word at offset 0x00 reads 0x22, with the output-enable-bar bit of both channels set. Every other register reads 0.
- R2: Each register at 0x04, 0x08–0x24 reads back the value last written to it, with unimplemented bits reading 0. Control-word bytes, on-time and period are 8 bits wide, and only bits 0 and 4 exist at 0x04. Any offset outside the map reads 0, and writes to it change nothing.
- R3: In the control word, channel n owns bits 4n..4n+3: start at bit 4n, output-enable-bar at bit 4n+1, force-high at bit 4n+2 and open-drain at bit 4n+3. Per-channel registers sit 8 bytes apart: control-word high byte at 0x08+8n, low byte at 0x0C+8n, on-time at 0x18+8n, period at 0x1C+8n.
- R4: Bit 4n of the select register at 0x04 routes the constant-frequency output to pin n when it is 1, and the variable-frequency output when it is 0.
- R5: While a channel is started, its 16-bit accumulator adds the 16-bit control word {high byte, low byte} on every clock. The variable-frequency output is the accumulator's top bit.
- R6: The constant-frequency counter advances by one on each clock in which the variable-frequency output is 1 but was 0 on the previous clock. It wraps to 0 from any value at or above the period. Its output is 1 while the count is below the on-time, so an on-time above the period gives a steady 1 and an on-time of 0 gives a steady 0.
- R7: While start is 0, both generators of the channel are cleared, and the pin is 0 unless force-high is set.
- R8: When force-high is 1, the pin is 1 regardless of start, select or generator state.
- R9: When output-enable-bar is 1, pad enable is 0. Otherwise, with open-drain 0 the pad enable is 1, and with open-drain 1 the pad enable is 1 only while the pin is 0. The open-drain output mirrors the open-drain bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_out | output | 2 | Pin value per channel |
| pin_oe | output | 2 | Pad output enable per channel |
| pin_od | output | 2 | Pad open-drain mode per channel |

## Verification
The bench builds the block with its default widths: 8-bit control-word halves, giving a 16-bit accumulator, and an 8-bit counter. Because the widths are small, control words such as 0x4000 and 0x2000 produce oscillator periods of 4 and 8 clocks. Several full constant-frequency periods, wraps, and on-time-above-period cases therefore fit in a few hundred cycles per phase. A behavioural model steps both channels every clock and is compared on pins, pad enables and readback. Directed readback checks cover reset values, unused bits and unmapped offsets.

// File: rtl/pwm2_pkg.sv
// Shared constants for the dual-channel PWM block: register offsets,
// per-channel field positions and the control-word reset value.
package pwm2_pkg;
    localparam int NUM_CH     = 2;
    localparam int FIELD_W    = 4;     // bits per channel in shared words
    localparam int REG_STRIDE = 8;     // bytes between per-channel registers

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_SEL  = 8'h04;
    localparam logic [7:0] OFF_CWH  = 8'h08;
    localparam logic [7:0] OFF_CWL  = 8'h0C;
    localparam logic [7:0] OFF_ONT  = 8'h18;
    localparam logic [7:0] OFF_PER  = 8'h1C;

    localparam int B_START = 0;
    localparam int B_OEB   = 1;
    localparam int B_FORCE = 2;
    localparam int B_OD    = 3;
    localparam int B_SEL   = 0;

    localparam int CTRL_W = NUM_CH * FIELD_W;

    // Control reset value: every output-enable-bar set, all else clear.
    function automatic logic [CTRL_W-1:0] ctrl_reset_value();
        logic [CTRL_W-1:0] v;
        v = '0;
        for (int ch = 0; ch < NUM_CH; ch++) v[ch*FIELD_W + B_OEB] = 1'b1;
        return v;
    endfunction

    // Byte offset of a per-channel register.
    function automatic logic [7:0] ch_offset(logic [7:0] base, int ch);
        return base + 8'(ch * REG_STRIDE);
    endfunction
endpackage

// File: rtl/pwm2_nco.sv
// Phase-accumulator oscillator. Adds the control word every clock
// while run is high; the top accumulator bit is the square-wave output.
// tick marks a clock where the output is 1 but was 0 one clock earlier.
// Assumes: run low clears the state synchronously.
module pwm2_nco #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] cword,
    output logic             wave,
    output logic             tick
);
    logic [ACC_W-1:0] acc;
    logic             wave_q;

    // Accumulate phase and remember the previous wave level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc    <= '0;
            wave_q <= 1'b0;
        end else begin
            acc    <= acc + cword;
            wave_q <= acc[ACC_W-1];
        end
    end

    assign wave = acc[ACC_W-1];
    assign tick = acc[ACC_W-1] & ~wave_q;
endmodule

// File: rtl/pwm2_cfgen.sv
// Period/on-time counter stepped by the oscillator tick. Wraps to zero
// at or above the period; output high while the count is below on-time.
// Assumes: run low clears the counter synchronously.
module pwm2_cfgen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] on_time,
    input  logic [CNT_W-1:0] period,
    output logic             wave
);
    logic [CNT_W-1:0] cnt;

    // Step the counter on each tick and wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt <= '0;
        else if (tick)        cnt <= (cnt >= period) ? '0 : cnt + 1'b1;
    end

    assign wave = (cnt < on_time);
endmodule

// File: rtl/pwm2_pad.sv
// Per-channel pin and pad control: force-high override, stop gating,
// source select, active-low enable and open-drain gating.
// Assumes: all inputs come from registers or generators of one channel.
module pwm2_pad (
    input  logic start,
    input  logic oe_n,
    input  logic force_hi,
    input  logic open_drain,
    input  logic use_cf,
    input  logic vf_wave,
    input  logic cf_wave,
    output logic pin,
    output logic oe,
    output logic od
);
    // Pin value by priority: force, stop, selected source.
    always_comb begin
        if (force_hi)      pin = 1'b1;
        else if (!start)   pin = 1'b0;
        else               pin = use_cf ? cf_wave : vf_wave;
    end

    // Pad enable: off when disabled, low-only when open-drain.
    always_comb begin
        if (oe_n)            oe = 1'b0;
        else if (open_drain) oe = ~pin;
        else                 oe = 1'b1;
    end

    assign od = open_drain;
endmodule

// File: rtl/pwm2_ctrl.sv
// Dual-channel PWM register block. Holds the shared control and select
// words and the per-channel control-word, on-time and period registers,
// decodes a single-cycle byte-offset bus and drives two pins.
// Assumes: one write per reg_wr cycle; reads are combinational.
module pwm2_ctrl #(
    parameter int HALF_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [1:0]  pin_out,
    output logic [1:0]  pin_oe,
    output logic [1:0]  pin_od
);
    import pwm2_pkg::*;

    localparam int ACC_W = 2 * HALF_W;
    localparam logic [CTRL_W-1:0] CTRL_RST = ctrl_reset_value();

    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_CH-1:0] sel_q;
    logic [HALF_W-1:0] cwh_q [NUM_CH];
    logic [HALF_W-1:0] cwl_q [NUM_CH];
    logic [CNT_W-1:0]  ont_q [NUM_CH];
    logic [CNT_W-1:0]  per_q [NUM_CH];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[31:CTRL_W];

    // Register writes with reset to the disabled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            sel_q  <= '0;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                cwh_q[ch] <= '0;
                cwl_q[ch] <= '0;
                ont_q[ch] <= '0;
                per_q[ch] <= '0;
            end
        end else if (reg_wr) begin
            if (reg_addr == OFF_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (reg_addr == OFF_SEL)
                    sel_q[ch] <= reg_wdata[ch*FIELD_W + B_SEL];
                if (reg_addr == ch_offset(OFF_CWH, ch)) cwh_q[ch] <= reg_wdata[HALF_W-1:0];
                if (reg_addr == ch_offset(OFF_CWL, ch)) cwl_q[ch] <= reg_wdata[HALF_W-1:0];
                if (reg_addr == ch_offset(OFF_ONT, ch)) ont_q[ch] <= reg_wdata[CNT_W-1:0];
                if (reg_addr == ch_offset(OFF_PER, ch)) per_q[ch] <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    // Readback mux; unmapped offsets and unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_CTRL) reg_rdata = 32'(ctrl_q);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (reg_addr == OFF_SEL)
                reg_rdata[ch*FIELD_W + B_SEL] = sel_q[ch];
            if (reg_addr == ch_offset(OFF_CWH, ch)) reg_rdata = 32'(cwh_q[ch]);
            if (reg_addr == ch_offset(OFF_CWL, ch)) reg_rdata = 32'(cwl_q[ch]);
            if (reg_addr == ch_offset(OFF_ONT, ch)) reg_rdata = 32'(ont_q[ch]);
            if (reg_addr == ch_offset(OFF_PER, ch)) reg_rdata = 32'(per_q[ch]);
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic run, vf, tk, cf;
        assign run = ctrl_q[ch*FIELD_W + B_START];

        pwm2_nco #(.ACC_W(ACC_W)) u_nco (
            .clk(clk), .rst_n(rst_n), .run(run),
            .cword({cwh_q[ch], cwl_q[ch]}), .wave(vf), .tick(tk)
        );

        pwm2_cfgen #(.CNT_W(CNT_W)) u_cf (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tk),
            .on_time(ont_q[ch]), .period(per_q[ch]), .wave(cf)
        );

        pwm2_pad u_pad (
            .start(run),
            .oe_n(ctrl_q[ch*FIELD_W + B_OEB]),
            .force_hi(ctrl_q[ch*FIELD_W + B_FORCE]),
            .open_drain(ctrl_q[ch*FIELD_W + B_OD]),
            .use_cf(sel_q[ch]),
            .vf_wave(vf), .cf_wave(cf),
            .pin(pin_out[ch]), .oe(pin_oe[ch]), .od(pin_od[ch])
        );
    end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
// Port-level properties of the dual-channel PWM block, bound to the top.
module pwm2_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [1:0]  pin_out,
    input logic [1:0]  pin_oe,
    input logic [1:0]  pin_od
);
    logic unused_chk;
    assign unused_chk = ^reg_wdata[31:8];

    // R1: first cycle out of reset has every pad disabled.
    assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == 2'b00));

    for (genvar ch = 0; ch < 2; ch++) begin : g_p
        // R9: writing output-enable-bar turns the pad off next cycle.
        assert_oeb_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 8'h00 && reg_wdata[4*ch+1]) |=> !pin_oe[ch]);
        // R8: writing force-high drives the pin high next cycle.
        assert_force_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 8'h00 && reg_wdata[4*ch+2]) |=> pin_out[ch]);
        // R7: stopping without force gives a low pin next cycle.
        assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 8'h00 && !reg_wdata[4*ch] && !reg_wdata[4*ch+2])
            |=> !pin_out[ch]);
        // R9: an open-drain pad only drives while the pin is low.
        assert_od_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_od[ch] && pin_oe[ch]) |-> !pin_out[ch]);
    end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od)
);

// File: tb/pwm2_ctrl_test.sv
module pwm2_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pin_out, pin_oe, pin_od;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    bit done = 0;

    pwm2_ctrl uut (.*);

    always #(CLK_P/2) clk = ~clk;

    // Behavioural model state.
    logic [7:0]  m_ctrl;
    logic [7:0]  m_sel;
    logic [7:0]  m_cwh[2], m_cwl[2], m_on[2], m_per[2];
    logic [15:0] m_acc[2];
    logic        m_prev[2];
    int          m_cnt[2];

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return {24'd0, m_ctrl};
            8'h04: return {24'd0, m_sel & 8'h11};
            8'h08: return {24'd0, m_cwh[0]};
            8'h10: return {24'd0, m_cwh[1]};
            8'h0C: return {24'd0, m_cwl[0]};
            8'h14: return {24'd0, m_cwl[1]};
            8'h18: return {24'd0, m_on[0]};
            8'h20: return {24'd0, m_on[1]};
            8'h1C: return {24'd0, m_per[0]};
            8'h24: return {24'd0, m_per[1]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_pin(int ch);
        logic st, fh, cf, vf;
        st = m_ctrl[4*ch];
        fh = m_ctrl[4*ch+2];
        vf = m_acc[ch][15];
        cf = (m_cnt[ch] < int'(m_on[ch]));
        if (fh) return 1'b1;
        if (!st) return 1'b0;
        return m_sel[4*ch] ? cf : vf;
    endfunction

    function automatic logic m_oe(int ch);
        if (m_ctrl[4*ch+1]) return 1'b0;
        if (m_ctrl[4*ch+3]) return ~m_pin(ch);
        return 1'b1;
    endfunction

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'h22; m_sel = 8'h00;
            for (int ch = 0; ch < 2; ch++) begin
                m_cwh[ch] = 0; m_cwl[ch] = 0; m_on[ch] = 0; m_per[ch] = 0;
                m_acc[ch] = 0; m_prev[ch] = 0; m_cnt[ch] = 0;
            end
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                if (!m_ctrl[4*ch]) begin
                    m_acc[ch] = 0; m_prev[ch] = 0; m_cnt[ch] = 0;
                end else begin
                    if (m_acc[ch][15] && !m_prev[ch])
                        m_cnt[ch] = (m_cnt[ch] >= int'(m_per[ch])) ? 0 : m_cnt[ch] + 1;
                    m_prev[ch] = m_acc[ch][15];
                    m_acc[ch] = m_acc[ch] + {m_cwh[ch], m_cwl[ch]};
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'h00: m_ctrl = reg_wdata[7:0];
                    8'h04: m_sel = reg_wdata[7:0] & 8'h11;
                    8'h08: m_cwh[0] = reg_wdata[7:0];
                    8'h10: m_cwh[1] = reg_wdata[7:0];
                    8'h0C: m_cwl[0] = reg_wdata[7:0];
                    8'h14: m_cwl[1] = reg_wdata[7:0];
                    8'h18: m_on[0] = reg_wdata[7:0];
                    8'h20: m_on[1] = reg_wdata[7:0];
                    8'h1C: m_per[0] = reg_wdata[7:0];
                    8'h24: m_per[1] = reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
        chk_on = 1;
    end

    string cur_tag = "R1";

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (chk_on && !done) begin
            check({cur_tag, " rdata R2 R3"}, reg_rdata, m_read(reg_addr));
            for (int ch = 0; ch < 2; ch++) begin
                check({cur_tag, " pin R4 R5 R6 R7 R8"}, 32'(pin_out[ch]), 32'(m_pin(ch)));
                check({cur_tag, " oe R9"}, 32'(pin_oe[ch]), 32'(m_oe(ch)));
                check({cur_tag, " od R9"}, 32'(pin_od[ch]), 32'(m_ctrl[4*ch+3]));
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #(CLK_P/4);
        check(tag, reg_rdata, exp);
    endtask

    task automatic run_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values.
        cur_tag = "R1";
        rd_expect(8'h00, 32'h22, "R1 ctrl reset");
        rd_expect(8'h04, 32'h0,  "R1 sel reset");
        rd_expect(8'h1C, 32'h0,  "R1 period reset");
        check("R1 pad off after reset", 32'(pin_oe), 32'd0);

        // R2 readback with unused bits and unmapped offsets.
        cur_tag = "R2";
        wr(8'h04, 32'hFFFF_FFFF);
        rd_expect(8'h04, 32'h11, "R2 select unused bits");
        wr(8'h04, 32'h0);
        wr(8'h10, 32'hABCD_1234);
        rd_expect(8'h10, 32'h34, "R2 cword high ch1");
        wr(8'h28, 32'hFFFF_FFFF);
        rd_expect(8'h28, 32'h0, "R2 unmapped read");
        rd_expect(8'h00, 32'h22, "R2 unmapped write ignored");

        // R3/R5 ch0 oscillator at cword 0x4000, ch1 counter at cword 0x2000.
        cur_tag = "R5";
        wr(8'h08, 32'h40); wr(8'h0C, 32'h00);
        wr(8'h10, 32'h20); wr(8'h14, 32'h00);
        wr(8'h20, 32'd2);  wr(8'h24, 32'd4);
        wr(8'h18, 32'd1);  wr(8'h1C, 32'd2);
        wr(8'h04, 32'h10);
        wr(8'h00, 32'h11);
        rd_expect(8'h00, 32'h11, "R3 ctrl field layout");
        check("R3 ch0 push-pull oe", 32'(pin_oe[0]), 32'd1);
        run_cycles(200);

        // R4 swap selection; R6 on-time above period then zero.
        cur_tag = "R4";
        wr(8'h04, 32'h01);
        run_cycles(150);
        cur_tag = "R6";
        wr(8'h18, 32'd5);
        run_cycles(80);
        check("R6 on above period steady high", 32'(pin_out[0]), 32'd1);
        wr(8'h18, 32'd0);
        run_cycles(80);
        check("R6 zero on-time steady low", 32'(pin_out[0]), 32'd0);
        wr(8'h18, 32'd2); wr(8'h1C, 32'd3);
        wr(8'h0C, 32'h37);
        run_cycles(300);

        // R9 open-drain on both channels.
        cur_tag = "R9";
        wr(8'h00, 32'h99);
        run_cycles(200);
        wr(8'h00, 32'hBB);
        run_cycles(20);
        check("R9 oeb disables pads", 32'(pin_oe), 32'd0);

        // R8 force-high over a running and a stopped channel.
        cur_tag = "R8";
        wr(8'h00, 32'h45);
        run_cycles(40);
        check("R8 forced pins high", 32'(pin_out), 32'd3);

        // R7 stop clears generators; restart from zero.
        cur_tag = "R7";
        wr(8'h00, 32'h00);
        run_cycles(20);
        check("R7 stopped pins low", 32'(pin_out), 32'd0);
        wr(8'h00, 32'h11);
        run_cycles(200);

        reg_addr = 8'h00;
        rst_n = 1'b0;
        cur_tag = "R1";
        run_cycles(3);
        rst_n = 1'b1;
        #(CLK_P/4);
        check("R1 pads off after second reset", 32'(pin_oe), 32'd0);
        run_cycles(4);
        finish_up();
    end
endmodule